// File: doc/BRIEF.md
# Polyphase Sample-Rate Interpolator

This block raises the sample rate of a signed sample stream by an integer factor L, so that a later stage can locate pulse edges on a grid finer than the original sampling period. Its output matches what would come from placing L-1 zero samples after every input sample and passing the result through an M-tap low-pass FIR whose cut-off lies at or below half the original sample rate. The zero samples are never multiplied. The M coefficients are split into L sub-filters of M/L taps each. Every sub-filter reads one shared history of the last M/L accepted samples at the input rate.

Each accepted input sample produces a burst of L output samples on L consecutive clock cycles. The burst runs in phase order, and each output is tagged with its phase index. Phase 0 is the original sample instant, shifted by the filter's group delay. The input has no back-pressure, so input samples must be at least L cycles apart. The coefficients are a parameter array scaled by 2^FRAC. Each sub-filter sums at full precision, then rounds and saturates the result to the output width. Parameters are checked at elaboration: M must be a multiple of L, L must be at least 2, and FRAC must be at least 1.

Top module: `ppi_interp`

## Requirements
- R1: While reset is high and on the cycle after it is released, out_valid is 0 and out_data is 0. Reset clears the sample history to zero, so the first burst after reset uses zero for every older sample.
- R2: An input sample is accepted on a rising edge where in_valid is 1. out_valid is then 1 for exactly L consecutive cycles, starting one edge after the capturing edge, and out_phase steps through 0, 1, ..., L-1 in that order.
- R3: Let x0 be the newest accepted sample and xk the sample accepted k samples earlier, for k = 0 .. M/L-1. The result for phase p is the sum over k of COEFS[p + k*L] * xk. With the default coefficients (0, 3277, 6554, 9830, 13107, 16384, 13107, 9830, 6554, 3277 for indices 0..9, L = 5, FRAC = 14) this is linear interpolation with unity DC gain.
- R4: Before saturation, the full-precision sum is rounded by adding 2^(FRAC-1) and then shifting arithmetically right by FRAC bits. Ties therefore round toward positive infinity, and negative sums do not round toward zero.
- R5: A rounded result above 2^(OUT_W-1)-1 is output as 2^(OUT_W-1)-1. A rounded result below -2^(OUT_W-1) is output as -2^(OUT_W-1).
- R6: in_data is ignored on any cycle where in_valid is 0. Such cycles neither shift the history nor start a burst.
- R7: Input samples spaced exactly L cycles apart produce an unbroken output stream. out_valid stays 1 and the phase wraps from L-1 straight back to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Marks in_data as a new sample to accept |
| in_data | input | DATA_W | Signed input sample |
| out_valid | output | 1 | Marks out_data as an interpolated sample |
| out_data | output | OUT_W | Signed, rounded and saturated output sample |
| out_phase | output | PH_W | Phase index of out_data, 0 .. L-1 |

## Verification
The checker assumes that the source never raises in_valid again fewer than L cycles after the previous accepted sample, because there is no way to stall the input. A counter in the checker measures that spacing and flags any violation. Given that assumption, the burst properties hold: bursts start exactly when expected, phases advance in order, and output stops after phase L-1 unless a new sample arrived on the edge before. Every directed stimulus task drives samples at a fixed spacing of L or more cycles, including the back-to-back case of exactly L. Cycles with in_valid low carry changing junk on in_data, so the ignore rule is exercised without breaking the spacing contract.

// File: rtl/ppi_pkg.sv
package ppi_pkg;

   // Burst sequencer state
   typedef enum logic {
      SEQ_IDLE = 1'b0,
      SEQ_RUN  = 1'b1
   } seq_state_e;

   // Width helper for phase indices (at least one bit)
   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/ppi_tapline.sv
// Shared sample history: taps_o[0] is the newest accepted sample.
module ppi_tapline #(
   parameter int DATA_W = 12,
   parameter int TAPS   = 2
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     push_i,
   input  logic signed [DATA_W-1:0] data_i,
   output logic signed [DATA_W-1:0] taps_o [TAPS]
);

   logic signed [DATA_W-1:0] stage_q [TAPS];

   generate
      if (TAPS == 1) begin : g_single
         always_ff @(posedge clk) begin
            if (rst)         stage_q[0] <= '0;
            else if (push_i) stage_q[0] <= data_i;
         end
      end else begin : g_chain
         always_ff @(posedge clk) begin
            if (rst)         stage_q[0] <= '0;
            else if (push_i) stage_q[0] <= data_i;
         end
         for (genvar k = 1; k < TAPS; k++) begin : g_stage
            always_ff @(posedge clk) begin
               if (rst)         stage_q[k] <= '0;
               else if (push_i) stage_q[k] <= stage_q[k-1];
            end
         end
      end
   endgenerate

   always_comb begin
      for (int k = 0; k < TAPS; k++) taps_o[k] = stage_q[k];
   end

endmodule

// File: rtl/ppi_branch.sv
// One polyphase sub-filter: coefficients COEFS[PHASE + k*L], k = 0..TAPS-1.
module ppi_branch #(
   parameter int DATA_W = 12,
   parameter int COEF_W = 16,
   parameter int OUT_W  = 16,
   parameter int FRAC   = 14,
   parameter int L      = 5,
   parameter int M      = 10,
   parameter int PHASE  = 0,
   parameter logic signed [COEF_W-1:0] COEFS [M] = '{default: '0}
) (
   input  logic signed [DATA_W-1:0] taps_i [M/L],
   output logic signed [OUT_W-1:0]  result_o
);

   localparam int TAPS   = M / L;
   localparam int PROD_W = DATA_W + COEF_W;
   localparam int ACC_W  = PROD_W + $clog2(TAPS + 1) + 1;
   localparam logic signed [ACC_W-1:0] HALF = ACC_W'(64'sd1 <<< (FRAC - 1));
   localparam logic signed [ACC_W-1:0] MAXV = ACC_W'((64'sd1 <<< (OUT_W - 1)) - 64'sd1);
   localparam logic signed [ACC_W-1:0] MINV = -MAXV - ACC_W'(1);

   logic signed [PROD_W-1:0] prod [TAPS];
   logic signed [ACC_W-1:0]  acc;
   logic signed [ACC_W-1:0]  scaled;

   generate
      for (genvar k = 0; k < TAPS; k++) begin : g_mac
         localparam logic signed [COEF_W-1:0] CK = COEFS[PHASE + k * L];
         assign prod[k] = taps_i[k] * CK;
      end
   endgenerate

   always_comb begin
      acc = '0;
      for (int k = 0; k < TAPS; k++) acc = acc + ACC_W'(prod[k]);
      scaled = (acc + HALF) >>> FRAC;
      if (scaled > MAXV)      result_o = MAXV[OUT_W-1:0];
      else if (scaled < MINV) result_o = MINV[OUT_W-1:0];
      else                    result_o = scaled[OUT_W-1:0];
   end

endmodule

// File: rtl/ppi_sequencer.sv
// Issues L consecutive phase slots after each accepted sample.
module ppi_sequencer
   import ppi_pkg::*;
#(
   parameter int L    = 5,
   parameter int PH_W = 3
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            start_i,
   output logic            active_o,
   output logic [PH_W-1:0] phase_o
);

   localparam logic [PH_W-1:0] LAST = PH_W'(L - 1);

   seq_state_e      state_q;
   logic [PH_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= SEQ_IDLE;
         cnt_q   <= '0;
      end else if (start_i) begin
         state_q <= SEQ_RUN;
         cnt_q   <= '0;
      end else if (state_q == SEQ_RUN) begin
         if (cnt_q == LAST) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
         end else begin
            cnt_q <= cnt_q + PH_W'(1);
         end
      end
   end

   assign active_o = (state_q == SEQ_RUN);
   assign phase_o  = cnt_q;

endmodule

// File: rtl/ppi_interp.sv
module ppi_interp
   import ppi_pkg::*;
#(
   parameter int DATA_W = 12,
   parameter int COEF_W = 16,
   parameter int OUT_W  = 16,
   parameter int FRAC   = 14,
   parameter int L      = 5,
   parameter int M      = 10,
   parameter logic signed [COEF_W-1:0] COEFS [M] = '{
      16'sd0,     16'sd3277,  16'sd6554, 16'sd9830, 16'sd13107,
      16'sd16384, 16'sd13107, 16'sd9830, 16'sd6554, 16'sd3277},
   localparam int PH_W = idx_width(L)
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     in_valid,
   input  logic signed [DATA_W-1:0] in_data,
   output logic                     out_valid,
   output logic signed [OUT_W-1:0]  out_data,
   output logic [PH_W-1:0]          out_phase
);

   localparam int TAPS = M / L;

   generate
      if (L < 2) begin : g_bad_l
         $error("ppi_interp: L must be at least 2");
      end
      if ((M % L) != 0 || M < L) begin : g_bad_m
         $error("ppi_interp: M must be a positive multiple of L");
      end
      if (FRAC < 1) begin : g_bad_frac
         $error("ppi_interp: FRAC must be at least 1");
      end
   endgenerate

   logic signed [DATA_W-1:0] taps [TAPS];
   logic signed [OUT_W-1:0]  branch_out [L];
   logic                     run_active;
   logic [PH_W-1:0]          run_phase;

   ppi_tapline #(
      .DATA_W (DATA_W),
      .TAPS   (TAPS)
   ) u_tapline (
      .clk    (clk),
      .rst    (rst),
      .push_i (in_valid),
      .data_i (in_data),
      .taps_o (taps)
   );

   generate
      for (genvar p = 0; p < L; p++) begin : g_branch
         ppi_branch #(
            .DATA_W (DATA_W),
            .COEF_W (COEF_W),
            .OUT_W  (OUT_W),
            .FRAC   (FRAC),
            .L      (L),
            .M      (M),
            .PHASE  (p),
            .COEFS  (COEFS)
         ) u_branch (
            .taps_i   (taps),
            .result_o (branch_out[p])
         );
      end
   endgenerate

   ppi_sequencer #(
      .L    (L),
      .PH_W (PH_W)
   ) u_seq (
      .clk      (clk),
      .rst      (rst),
      .start_i  (in_valid),
      .active_o (run_active),
      .phase_o  (run_phase)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         out_data  <= '0;
         out_phase <= '0;
      end else if (run_active) begin
         out_valid <= 1'b1;
         out_data  <= branch_out[run_phase];
         out_phase <= run_phase;
      end else begin
         out_valid <= 1'b0;
      end
   end

endmodule

// File: rtl/ppi_interp_checks.sv
module ppi_interp_checks #(
   parameter int L    = 5,
   parameter int PH_W = 3
) (
   input logic            clk,
   input logic            rst,
   input logic            in_valid,
   input logic            out_valid,
   input logic [PH_W-1:0] out_phase
);

   localparam int GW = $clog2(L + 1) + 1;
   localparam logic [GW-1:0] GAP_MIN = GW'(L);

   logic [GW-1:0] gap_cnt;

   always_ff @(posedge clk) begin
      if (rst)                     gap_cnt <= GAP_MIN;
      else if (in_valid)           gap_cnt <= GW'(1);
      else if (gap_cnt < GAP_MIN)  gap_cnt <= gap_cnt + GW'(1);
   end

   // R7: the input contract, samples at least L cycles apart
   assert_input_spacing_R7: assert property (@(posedge clk) disable iff (rst)
      in_valid |-> gap_cnt >= GAP_MIN);

   // R1: output idle after reset
   assert_reset_idle_R1: assert property (@(posedge clk)
      rst |=> !out_valid);

   // R2: a burst opens with phase 0 one edge after capture
   assert_burst_start_R2: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> ##1 (out_valid && out_phase == '0));

   // R2: phases advance by one inside a burst
   assert_phase_step_R2: assert property (@(posedge clk) disable iff (rst)
      (out_valid && out_phase != PH_W'(L - 1)) |=>
         (out_valid && out_phase == $past(out_phase) + PH_W'(1)));

   // R2: phase never leaves 0 .. L-1
   assert_phase_range_R2: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> out_phase < PH_W'(L));

   // R2: burst ends after phase L-1 unless a new sample arrived
   assert_burst_end_R2: assert property (@(posedge clk) disable iff (rst)
      (out_valid && out_phase == PH_W'(L - 1) && !$past(in_valid)) |=> !out_valid);

endmodule

bind ppi_interp ppi_interp_checks #(
   .L    (L),
   .PH_W (PH_W)
) u_checks (
   .clk       (clk),
   .rst       (rst),
   .in_valid  (in_valid),
   .out_valid (out_valid),
   .out_phase (out_phase)
);

// File: tb/ppi_interp_test.sv
`timescale 1ns/1ps
module ppi_interp_test;

   localparam int L = 5;
   localparam int M = 10;
   localparam int TAPS = M / L;
   localparam int DATA_W = 12;
   localparam int OUT_W = 12;
   localparam int COEF_W = 16;
   localparam int FRAC = 14;
   localparam int PH_W = 3;

   // Bench coefficients: phase 0 has gain 2, phase 4 has a negative tap
   localparam logic signed [COEF_W-1:0] TB_H [M] = '{
      16'sd16384, 16'sd3277,  16'sd6554, 16'sd9830, 16'sd13107,
      16'sd16384, 16'sd13107, 16'sd9830, 16'sd6554, -16'sd3277};

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic in_valid = 1'b0;
   logic signed [DATA_W-1:0] in_data = '0;
   logic out_valid;
   logic signed [OUT_W-1:0] out_data;
   logic [PH_W-1:0] out_phase;

   int n_checks = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   longint hist [TAPS];
   logic signed [DATA_W-1:0] seq_x [32];

   always #2 clk = ~clk;

   ppi_interp #(
      .DATA_W (DATA_W),
      .COEF_W (COEF_W),
      .OUT_W  (OUT_W),
      .FRAC   (FRAC),
      .L      (L),
      .M      (M),
      .COEFS  (TB_H)
   ) uut (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (in_valid),
      .in_data   (in_data),
      .out_valid (out_valid),
      .out_data  (out_data),
      .out_phase (out_phase)
   );

   task automatic chk(input string tag, input string what, input longint act, input longint exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   // Reference per R3, R4, R5
   function automatic longint model_phase(input int p);
      longint acc = 0;
      longint r;
      longint hi = (64'sd1 <<< (OUT_W - 1)) - 1;
      longint lo = -(64'sd1 <<< (OUT_W - 1));
      for (int k = 0; k < TAPS; k++) acc += longint'(TB_H[p + k * L]) * hist[k];
      r = (acc + (64'sd1 <<< (FRAC - 1))) >>> FRAC;
      if (r > hi) r = hi;
      if (r < lo) r = lo;
      return r;
   endfunction

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      in_valid = 1'b0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      for (int k = 0; k < TAPS; k++) hist[k] = 0;
   endtask

   // Drives n samples, one every gap cycles, junk on idle cycles; checks every cycle.
   task automatic run_seq(input int n, input int gap, input string tag);
      int drv_c [32];
      longint drv_v [32][L];
      int nd = 0;
      int total = (n - 1) * gap + L + 4;
      for (int t = 0; t < total; t++) begin
         int sel = -1;
         @(negedge clk);
         for (int i = 0; i < nd; i++) if (drv_c[i] <= t - 2) sel = i;
         if (sel >= 0 && (t - 2 - drv_c[sel]) < L) begin
            int p = t - 2 - drv_c[sel];
            chk(tag, "out_valid", longint'(out_valid), 1);
            chk(tag, "out_phase", longint'(out_phase), p);
            chk(tag, "out_data", longint'(out_data), drv_v[sel][p]);
         end else begin
            chk(tag, "out_valid idle", longint'(out_valid), 0);
         end
         if ((t % gap) == 0 && (t / gap) < n) begin
            in_valid = 1'b1;
            in_data = seq_x[t / gap];
            for (int k = TAPS - 1; k > 0; k--) hist[k] = hist[k-1];
            hist[0] = longint'(seq_x[t / gap]);
            for (int p = 0; p < L; p++) drv_v[nd][p] = model_phase(p);
            drv_c[nd] = t;
            nd++;
         end else begin
            in_valid = 1'b0;
            in_data = DATA_W'(t * 613 + 1291);
         end
      end
      in_valid = 1'b0;
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk("R1", "out_valid in reset", longint'(out_valid), 0);
      chk("R1", "out_data in reset", longint'(out_data), 0);
      rst = 1'b0;
      for (int k = 0; k < TAPS; k++) hist[k] = 0;
      @(negedge clk);
      chk("R1", "out_valid after release", longint'(out_valid), 0);
      chk("R1", "out_data after release", longint'(out_data), 0);
   endtask

   task automatic t_impulse();
      // R3: impulse then zero reveals each coefficient by phase
      seq_x[0] = 12'sd1000;
      seq_x[1] = 12'sd0;
      seq_x[2] = 12'sd0;
      run_seq(3, L + 1, "R3");
   endtask

   task automatic t_back_to_back();
      // R7: spacing exactly L, mixed signs
      seq_x[0] = 12'sd300;
      seq_x[1] = -12'sd750;
      seq_x[2] = 12'sd1200;
      seq_x[3] = -12'sd5;
      seq_x[4] = 12'sd77;
      run_seq(5, L, "R7");
   endtask

   task automatic t_rounding();
      // R4: small and negative values where floor and truncation differ
      seq_x[0] = 12'sd1;
      seq_x[1] = -12'sd1;
      seq_x[2] = 12'sd3;
      seq_x[3] = -12'sd3;
      seq_x[4] = -12'sd7;
      seq_x[5] = 12'sd2;
      run_seq(6, L, "R4");
   endtask

   task automatic t_saturation();
      // R5: phase 0 gain 2 drives both limits
      seq_x[0] = 12'sd2047;
      seq_x[1] = 12'sd2047;
      seq_x[2] = -12'sd2048;
      seq_x[3] = -12'sd2048;
      run_seq(4, L + 2, "R5");
   endtask

   task automatic t_ignore();
      // R6: long gaps filled with junk on in_data
      seq_x[0] = 12'sd640;
      seq_x[1] = -12'sd320;
      seq_x[2] = 12'sd111;
      run_seq(3, 3 * L, "R6");
   endtask

   task automatic t_reset_mid();
      // R1: reset mid-burst stops output and clears history
      seq_x[0] = 12'sd900;
      in_valid = 1'b1;
      in_data = seq_x[0];
      @(negedge clk);
      in_valid = 1'b0;
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      chk("R1", "out_valid mid reset", longint'(out_valid), 0);
      chk("R1", "out_data mid reset", longint'(out_data), 0);
      rst = 1'b0;
      for (int k = 0; k < TAPS; k++) hist[k] = 0;
      seq_x[0] = 12'sd500;
      run_seq(1, L, "R1");
   endtask

   initial begin
      for (int k = 0; k < TAPS; k++) hist[k] = 0;
      repeat (3) @(negedge clk);
      t_reset();
      t_impulse();
      t_back_to_back();
      t_rounding();
      t_saturation();
      t_ignore();
      t_reset_mid();
      do_reset();
      t_impulse();
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

   initial begin
      #(200000 * 4);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   end

endmodule